// File: doc/BRIEF.md
# PCI Target Window Decoder

This block is the front end of a PCI target. It looks at every address phase and sorts the command nibble into three groups: configuration, memory, or ignored. It claims the transaction only when the command and the address match one of its targets:

- a configuration access, when the configuration select is high;
- a 4 KB local register aperture;
- a 2 MB forwarding window.

Data phases of a window hit become internal-bus requests that carry a 21-bit offset. Data phases of an aperture hit go to a local register port. Configuration data phases read or write the two base registers.

In a burst, the block counts the address up by one dword for each completed data phase. It signals a disconnect on the last dword before the window edge, so that a forwarded burst never wraps past the window. The register aperture is decoded ahead of the window. An address that lies in both therefore always reaches the local register port and never the internal bus.

A static control input selects the command type that forwarded requests use on the internal bus: I/O or memory.

Top module: `pci_win_target`

## Requirements
- R1: After reset, claim, stop, ireq and rreq are low, and both base registers read back as zero.
- R2: Memory commands 0110, 0111, 1100, 1110 and 1111 are claimed when they hit the window or the aperture. Commands 0000, 0001, 0010, 0011 and 1101 are never claimed, and neither are the reserved codes 0100, 0101, 1000 and 1001. Claim rises in the cycle after the start strobe.
- R3: Configuration commands 1010 (read) and 1011 (write) are claimed only when cfg_sel is high, whatever the address. The dword index ad[7:2] selects a base register. Index 4 holds the window base in bits 31:21. Index 5 holds the register base in bits 31:12. Other indices read zero, and writes to them are ignored.
- R4: A memory access with ad[31:21] equal to a nonzero window base drives ireq on each completed data phase. ioff carries address bits 20:0. iwr is high for commands 0111 and 1111 and low for read commands.
- R5: A memory access with ad[31:12] equal to a nonzero register base drives rreq with roff equal to address bits 11:0. This decode wins over a window hit, so an overlapped address never raises ireq.
- R6: Each completed data phase advances the transfer address by 4.
- R7: stop is high during a window data phase whose offset bits 20:2 are all ones. When that phase completes, claim falls in the next cycle, and later data phases raise no request.
- R8: During ireq, imem equals io_mode (0 selects I/O commands, 1 selects memory commands).
- R9: A completed data phase with last high ends the transaction, and claim is low in the next cycle.
- R10: A base register that holds zero disables its decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_mode | input | 1 | Internal bus command type: 0 selects I/O, 1 selects memory |
| start | input | 1 | Address phase strobe |
| ad | input | 32 | Address during the address phase |
| cmd | input | 4 | Bus command during the address phase |
| cfg_sel | input | 1 | Configuration select |
| xfer | input | 1 | A data phase completes in this cycle |
| last | input | 1 | The completing data phase is the initiator's final one |
| wdata | input | 32 | Write data of the data phase |
| claim | output | 1 | The transaction is claimed |
| stop | output | 1 | Disconnect at the window edge |
| ireq | output | 1 | Internal-bus request |
| iwr | output | 1 | The internal request is a write |
| imem | output | 1 | The internal request uses a memory command |
| ioff | output | 21 | Window offset of the request |
| rreq | output | 1 | Local register port request |
| rwr | output | 1 | The register request is a write |
| roff | output | 12 | Register offset |
| fwd_wdata | output | 32 | Write data forwarded to the internal bus and the register port |
| cfg_rdata | output | 32 | Configuration read data |

## Verification
All sixteen command codes are sent to one address inside the window, with cfg_sel low. This separates the command filter from the address decode.

Configuration accesses are tried with the select high and then low. They are also tried at an unmapped index, which tells a real register write from an ignored one.

A read burst sits wholly inside the window. A write burst starts two dwords below the window edge. Comparing the two separates plain linear stepping from the disconnect and the suppression of later phases.

Accesses into the aperture placed inside the window, and accesses after the window base is cleared, separate the decode priority from the enable.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CFG  = 2'd1,
        TGT_REG  = 2'd2,
        TGT_WIN  = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e kind;
        logic write;
    } claim_t;

    localparam logic [3:0] CMD_MEM_RD   = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR   = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD   = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR   = 4'b1011;
    localparam logic [3:0] CMD_MEM_RDM  = 4'b1100;
    localparam logic [3:0] CMD_MEM_RDL  = 4'b1110;
    localparam logic [3:0] CMD_MEM_WRI  = 4'b1111;

    function automatic logic is_mem_cmd(logic [3:0] c);
        return (c == CMD_MEM_RD) || (c == CMD_MEM_WR) || (c == CMD_MEM_RDM) ||
               (c == CMD_MEM_RDL) || (c == CMD_MEM_WRI);
    endfunction

    function automatic logic is_cfg_cmd(logic [3:0] c);
        return (c == CMD_CFG_RD) || (c == CMD_CFG_WR);
    endfunction

    function automatic logic is_write_cmd(logic [3:0] c);
        return (c == CMD_MEM_WR) || (c == CMD_MEM_WRI) || (c == CMD_CFG_WR);
    endfunction

endpackage

// File: rtl/pwt_cfg_regs.sv
module pwt_cfg_regs #(
    parameter int ADDR_W   = 32,
    parameter int WIN_AW   = 21,
    parameter int REG_AW   = 12,
    parameter int WBASE_DW = 4,
    parameter int RBASE_DW = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [5:0]               dw_idx,
    input  logic [ADDR_W-1:REG_AW]   wdata_hi,
    output logic [ADDR_W-1:WIN_AW]   wbase,
    output logic [ADDR_W-1:REG_AW]   rbase,
    output logic [ADDR_W-1:0]        rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wbase <= '0;
            rbase <= '0;
        end else if (wr_en) begin
            if (dw_idx == 6'(WBASE_DW)) wbase <= wdata_hi[ADDR_W-1:WIN_AW];
            if (dw_idx == 6'(RBASE_DW)) rbase <= wdata_hi;
        end
    end

    always_comb begin
        rdata = '0;
        if (dw_idx == 6'(WBASE_DW)) rdata[ADDR_W-1:WIN_AW] = wbase;
        if (dw_idx == 6'(RBASE_DW)) rdata[ADDR_W-1:REG_AW] = rbase;
    end

    // R3: base registers only change on a configuration write
    a_r3_base_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(wbase) && $stable(rbase)));

endmodule

// File: rtl/pwt_decode.sv
module pwt_decode
    import pwt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WIN_AW = 21,
    parameter int REG_AW = 12
) (
    input  logic [ADDR_W-1:REG_AW] hi_addr,
    input  logic [3:0]             cmd,
    input  logic                   cfg_sel,
    input  logic [ADDR_W-1:WIN_AW] wbase,
    input  logic [ADDR_W-1:REG_AW] rbase,
    output claim_t                 dec
);
    logic reg_hit, win_hit;

    always_comb begin
        reg_hit   = (rbase != '0) && (hi_addr == rbase);
        win_hit   = (wbase != '0) && (hi_addr[ADDR_W-1:WIN_AW] == wbase);
        dec.write = is_write_cmd(cmd);
        if (is_cfg_cmd(cmd) && cfg_sel)
            dec.kind = TGT_CFG;
        else if (is_mem_cmd(cmd) && reg_hit)
            dec.kind = TGT_REG;
        else if (is_mem_cmd(cmd) && win_hit)
            dec.kind = TGT_WIN;
        else
            dec.kind = TGT_NONE;
    end

endmodule

// File: rtl/pwt_burst.sv
module pwt_burst
    import pwt_pkg::*;
#(
    parameter int WIN_AW = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WIN_AW-1:0] ad_lo,
    input  claim_t            dec,
    input  logic              xfer,
    input  logic              last,
    output logic              active,
    output tgt_e              kind,
    output logic              write,
    output logic [WIN_AW-1:0] off,
    output logic              stop
);
    localparam logic [WIN_AW-1:0] STEP = WIN_AW'(4);

    always_comb stop = active && (kind == TGT_WIN) && (&off[WIN_AW-1:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            kind   <= TGT_NONE;
            write  <= 1'b0;
            off    <= '0;
        end else if (!active) begin
            if (start && dec.kind != TGT_NONE) begin
                active <= 1'b1;
                kind   <= dec.kind;
                write  <= dec.write;
                off    <= {ad_lo[WIN_AW-1:2], 2'b00};
            end
        end else if (xfer) begin
            off <= off + STEP;
            if (last || stop) active <= 1'b0;
        end
    end

    // R2: a claim only begins after an address phase
    a_r2_claim_after_start: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(start));
    // R6: linear dword stepping inside a burst
    a_r6_step: assert property (@(posedge clk) disable iff (rst)
        (active && xfer && !last && !stop) |=> (off == $past(off) + STEP));
    // R7: disconnect ends the transaction
    a_r7_stop_ends: assert property (@(posedge clk) disable iff (rst)
        (active && xfer && stop) |=> !active);
    // R9: final phase ends the transaction
    a_r9_last_ends: assert property (@(posedge clk) disable iff (rst)
        (active && xfer && last) |=> !active);

endmodule

// File: rtl/pci_win_target.sv
module pci_win_target
    import pwt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_AW   = 21,
    parameter int REG_AW   = 12,
    parameter int WBASE_DW = 4,
    parameter int RBASE_DW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_mode,
    input  logic              start,
    input  logic [ADDR_W-1:0] ad,
    input  logic [3:0]        cmd,
    input  logic              cfg_sel,
    input  logic              xfer,
    input  logic              last,
    input  logic [ADDR_W-1:0] wdata,
    output logic              claim,
    output logic              stop,
    output logic              ireq,
    output logic              iwr,
    output logic              imem,
    output logic [WIN_AW-1:0] ioff,
    output logic              rreq,
    output logic              rwr,
    output logic [REG_AW-1:0] roff,
    output logic [ADDR_W-1:0] fwd_wdata,
    output logic [ADDR_W-1:0] cfg_rdata
);
    logic [ADDR_W-1:WIN_AW] wbase;
    logic [ADDR_W-1:REG_AW] rbase;
    logic [ADDR_W-1:0]      reg_rdata;
    claim_t                 dec;
    tgt_e                   kind;
    logic                   write;
    logic [WIN_AW-1:0]      off;
    logic                   cfg_wr;

    pwt_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .REG_AW(REG_AW)) u_dec (
        .hi_addr (ad[ADDR_W-1:REG_AW]),
        .cmd     (cmd),
        .cfg_sel (cfg_sel),
        .wbase   (wbase),
        .rbase   (rbase),
        .dec     (dec)
    );

    pwt_burst #(.WIN_AW(WIN_AW)) u_burst (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .ad_lo  (ad[WIN_AW-1:0]),
        .dec    (dec),
        .xfer   (xfer),
        .last   (last),
        .active (claim),
        .kind   (kind),
        .write  (write),
        .off    (off),
        .stop   (stop)
    );

    always_comb cfg_wr = claim && (kind == TGT_CFG) && write && xfer;

    pwt_cfg_regs #(
        .ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .REG_AW(REG_AW),
        .WBASE_DW(WBASE_DW), .RBASE_DW(RBASE_DW)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr),
        .dw_idx   (off[7:2]),
        .wdata_hi (wdata[ADDR_W-1:REG_AW]),
        .wbase    (wbase),
        .rbase    (rbase),
        .rdata    (reg_rdata)
    );

    always_comb begin
        ireq      = claim && (kind == TGT_WIN) && xfer;
        iwr       = ireq && write;
        imem      = ireq && io_mode;
        ioff      = off;
        rreq      = claim && (kind == TGT_REG) && xfer;
        rwr       = rreq && write;
        roff      = off[REG_AW-1:0];
        fwd_wdata = wdata;
        cfg_rdata = (claim && kind == TGT_CFG) ? reg_rdata : '0;
    end

    // R5: forwarded and local requests never coincide
    a_r5_one_port: assert property (@(posedge clk) disable iff (rst)
        !(ireq && rreq));
    // R7: a disconnect is only signalled inside a claimed transaction
    a_r7_stop_claimed: assert property (@(posedge clk) disable iff (rst)
        stop |-> claim);

endmodule

// File: tb/pci_win_target_test.sv
module pci_win_target_test;
    logic        clk = 1'b0;
    logic        rst, io_mode, start, cfg_sel, xfer, last;
    logic [31:0] ad, wdata;
    logic [3:0]  cmd;
    logic        claim, stop, ireq, iwr, imem, rreq, rwr;
    logic [20:0] ioff;
    logic [11:0] roff;
    logic [31:0] fwd_wdata, cfg_rdata;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string tag = "R1";

    pci_win_target uut (
        .clk(clk), .rst(rst), .io_mode(io_mode), .start(start), .ad(ad), .cmd(cmd),
        .cfg_sel(cfg_sel), .xfer(xfer), .last(last), .wdata(wdata),
        .claim(claim), .stop(stop), .ireq(ireq), .iwr(iwr), .imem(imem), .ioff(ioff),
        .rreq(rreq), .rwr(rwr), .roff(roff), .fwd_wdata(fwd_wdata), .cfg_rdata(cfg_rdata)
    );

    always #2 clk = ~clk;

    // behavioural reference state
    bit          m_act;
    int          m_kind;   // 0 none, 1 config, 2 register, 3 window
    bit          m_wr;
    logic [31:0] m_addr;
    logic [10:0] m_wb;
    logic [19:0] m_rb;

    function automatic int classify(logic [3:0] c, logic [31:0] a, logic sel);
        bit mem;
        mem = 0;
        case (c)
            4'b1010, 4'b1011: return sel ? 1 : 0;
            4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: mem = 1;
            default: mem = 0;
        endcase
        if (!mem) return 0;
        if (m_rb != 0 && a[31:12] == m_rb) return 2;
        if (m_wb != 0 && a[31:21] == m_wb) return 3;
        return 0;
    endfunction

    function automatic bit edge_dw();
        return m_act && m_kind == 3 && m_addr[20:2] == 19'h7FFFF;
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_act = 0; m_kind = 0; m_wr = 0; m_addr = 0; m_wb = 0; m_rb = 0;
        end else if (!m_act) begin
            if (start && classify(cmd, ad, cfg_sel) != 0) begin
                m_act  = 1;
                m_kind = classify(cmd, ad, cfg_sel);
                m_wr   = (cmd == 4'b0111 || cmd == 4'b1111 || cmd == 4'b1011);
                m_addr = {ad[31:2], 2'b00};
            end
        end else if (xfer) begin
            if (m_kind == 1 && m_wr) begin
                if (m_addr[7:2] == 6'd4) m_wb = wdata[31:21];
                if (m_addr[7:2] == 6'd5) m_rb = wdata[31:12];
            end
            if (last || edge_dw()) m_act = 0;
            m_addr = m_addr + 4;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            bit e_ireq, e_rreq;
            logic [31:0] e_rd;
            e_ireq = m_act && m_kind == 3 && xfer;
            e_rreq = m_act && m_kind == 2 && xfer;
            e_rd = 0;
            if (m_act && m_kind == 1) begin
                if (m_addr[7:2] == 6'd4) e_rd = {m_wb, 21'b0};
                if (m_addr[7:2] == 6'd5) e_rd = {m_rb, 12'b0};
            end
            chk("claim", 32'(claim), 32'(m_act));
            chk("stop", 32'(stop), 32'(edge_dw()));
            chk("ireq", 32'(ireq), 32'(e_ireq));
            chk("iwr", 32'(iwr), 32'(e_ireq && m_wr));
            chk("imem", 32'(imem), 32'(e_ireq && io_mode));
            if (e_ireq) chk("ioff", 32'(ioff), 32'(m_addr[20:0]));
            chk("rreq", 32'(rreq), 32'(e_rreq));
            chk("rwr", 32'(rwr), 32'(e_rreq && m_wr));
            if (e_rreq) chk("roff", 32'(roff), 32'(m_addr[11:0]));
            chk("fwd_wdata", fwd_wdata, wdata);
            chk("cfg_rdata", cfg_rdata, e_rd);
        end
    end

    task automatic idle();
        @(negedge clk);
        start = 0; xfer = 0; last = 0;
    endtask

    task automatic txn(logic [3:0] c, logic [31:0] a, logic sel, int n, logic [31:0] d);
        @(negedge clk);
        start = 1; cmd = c; ad = a; cfg_sel = sel; xfer = 0; last = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 0; xfer = 1; last = (i == n - 1); wdata = d + 32'(i);
        end
        idle();
    endtask

    initial begin
        rst = 1; io_mode = 0; start = 0; cfg_sel = 0; xfer = 0; last = 0;
        ad = 0; wdata = 0; cmd = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        tag = "R1"; idle(); idle();
        txn(4'b1010, 32'h10, 1, 1, 0);                 // base reads zero after reset
        tag = "R10"; txn(4'b0110, 32'h0000_0100, 0, 1, 0); // zero bases claim nothing
        tag = "R3";
        txn(4'b1011, 32'h10, 1, 1, 32'h00A0_0000);     // window base
        txn(4'b1011, 32'h14, 1, 1, 32'h00A8_0000);     // register base inside window
        txn(4'b1011, 32'h18, 1, 1, 32'hFFFF_FFFF);     // unmapped index ignored
        txn(4'b1010, 32'h10, 1, 2, 0);                 // read both bases
        txn(4'b1010, 32'h18, 1, 1, 0);
        txn(4'b1011, 32'h10, 0, 1, 32'h0120_0000);     // select low: not claimed
        txn(4'b1010, 32'h10, 1, 1, 0);
        tag = "R2";
        for (int c = 0; c < 16; c++) begin
            io_mode = c[0];
            txn(4'(c), 32'h00A0_0100, 0, 1, 32'h5000 + 32'(c));
        end
        tag = "R4"; io_mode = 1; txn(4'b0111, 32'h00A1_2340, 0, 1, 32'h1111);
        tag = "R8"; io_mode = 0; txn(4'b0110, 32'h00A1_2340, 0, 1, 0);
        tag = "R6"; io_mode = 1; txn(4'b1110, 32'h00A0_0FF0, 0, 4, 0);
        tag = "R5"; txn(4'b0111, 32'h00A8_0010, 0, 3, 32'h2222);
        txn(4'b1100, 32'h00A8_0FFC, 0, 2, 0);
        tag = "R7"; txn(4'b0111, 32'h00BF_FFF8, 0, 4, 32'h3333);
        txn(4'b0110, 32'h00BF_FFFC, 0, 3, 0);
        tag = "R9"; txn(4'b0110, 32'h00B0_0000, 0, 1, 0);
        tag = "R10";
        txn(4'b1011, 32'h10, 1, 1, 32'h0000_0000);
        txn(4'b0110, 32'h00A0_0100, 0, 1, 0);
        txn(4'b0110, 32'h00A8_0100, 0, 1, 0);
        repeat (3) idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 50000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule